// File: doc/BRIEF.md
# Streaming DMA Burst Writer

This block moves a programmed run of 64-bit words into a contiguous stretch of system memory over an AXI4 write port. It contains its own word generator and a small staging FIFO. The generator is loaded with a seed and a count and produces consecutive counter values. The writer is loaded with a byte address and a word count. It cuts the run into incrementing bursts and streams the FIFO contents out as data beats. It retires a transfer only after every burst has been answered on the response channel.

Software loads the generator and the writer, pulses both start inputs, and then waits for `done`. Three handshake counters report how many write-address, write-data and write-response transfers the last run produced. The sticky `err` flag shows whether any response was something other than OKAY. Both the counters and the flag stay readable after the run for debugging, and the next accepted start clears them.

Top module: `dma_burst_writer`

## Requirements
- R1: While `rst_n` is low, and after it is released with no start pulse, `m_awvalid`, `m_wvalid`, `busy`, `done` and `err` are 0 and all three handshake counters read 0.
- R2: Every address request uses burst type INCR (`m_awburst` = 2'b01) and a beat size of 8 bytes (`m_awsize` = 3'd3). The first burst address is `cfg_addr` with its three low bits cleared. Each later burst starts at the previous burst address plus 8 bytes times its beat count.
- R3: Each burst carries min(MAX_BEATS, words still unissued, words left before the next BOUNDARY-byte address boundary) beats, reported as `m_awlen` = beats − 1. No burst ever spans such a boundary.
- R4: `m_wlast` is 1 exactly on the final beat of each burst, and `m_wstrb` is 8'hFF on every beat.
- R5: While `m_awvalid` or `m_wvalid` is held against a low ready, the request and its payload do not change.
- R6: Data beats of a burst follow its accepted address request. `m_wvalid` is raised only while staged data exists, and is never raised when the block is idle. The total number of beats equals the programmed word count.
- R7: `done` rises only once the response count equals the burst count. It then stays 1 until the next accepted start. A start with a word count of 0 issues no burst and still reaches `done`.
- R8: A response with `m_bresp` other than 2'b00 sets `err`. The flag stays set through the rest of the run and after it, and an accepted start clears it.
- R9: `cnt_aw`, `cnt_w` and `cnt_b` count the handshakes on the address, data and response channels since the last accepted start.
- R10: The generator emits words seed, seed+1, seed+2 … (modulo 2^64). It emits exactly the programmed count, and these words appear on `m_wdata` in that order.
- R11: A `start` pulse that arrives while `busy` is 1 is ignored. Neither the burst addresses nor the lengths of the running transfer change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | ADDR_W | Byte start address of the run |
| cfg_words | input | CNT_W | Number of 64-bit words to write |
| start | input | 1 | One-cycle pulse that starts the writer |
| src_seed | input | DATA_W | First value produced by the generator |
| src_count | input | CNT_W | Number of words the generator produces |
| src_start | input | 1 | One-cycle pulse that loads the generator |
| m_awaddr | output | ADDR_W | Burst start address |
| m_awlen | output | 8 | Beats in burst minus one |
| m_awsize | output | 3 | Beat size code (8 bytes) |
| m_awburst | output | 2 | Burst type (INCR) |
| m_awvalid | output | 1 | Address request valid |
| m_awready | input | 1 | Address request accepted |
| m_wdata | output | DATA_W | Beat data |
| m_wstrb | output | DATA_W/8 | Byte enables, all ones |
| m_wlast | output | 1 | Final beat of burst |
| m_wvalid | output | 1 | Beat valid |
| m_wready | input | 1 | Beat accepted |
| m_bresp | input | 2 | Write response code |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Response accepted (always 1) |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Last run fully answered |
| err | output | 1 | Sticky non-OKAY response flag |
| cnt_aw | output | CNT_W | Address handshakes this run |
| cnt_w | output | CNT_W | Data handshakes this run |
| cnt_b | output | CNT_W | Response handshakes this run |

## Verification
The bench builds the writer with MAX_BEATS = 8, BOUNDARY = 256 and FIFO_DEPTH = 4. With these values, runs of a few dozen words span several length caps and cross boundaries. The shallow FIFO lets a throttled slave make the data path stall against both an empty and a full stage. A start address 16 bytes below a 256-byte line forces a two-beat opening burst. A seed two below 2^64 exercises counter wraparound within a short run.

// File: rtl/dmaw_pkg.sv
package dmaw_pkg;
  typedef enum logic [1:0] {
    WR_IDLE  = 2'd0,
    WR_ADDR  = 2'd1,
    WR_DATA  = 2'd2,
    WR_DRAIN = 2'd3
  } wr_state_t;

  localparam logic [1:0] BURST_INCR = 2'b01;
  localparam logic [1:0] RESP_OKAY  = 2'b00;
endpackage

// File: rtl/dmaw_pattern_src.sv
module dmaw_pattern_src #(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] seed,
  input  logic [CNT_W-1:0]  count,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  logic [DATA_W-1:0] val_q, val_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic              en;

  assign out_valid = (left_q != '0);
  assign out_data  = val_q;

  always_comb begin
    val_d  = val_q;
    left_d = left_q;
    en     = 1'b0;
    if (load) begin
      val_d  = seed;
      left_d = count;
      en     = 1'b1;
    end else if (out_valid && out_ready) begin
      val_d  = val_q + 1'b1;
      left_d = left_q - 1'b1;
      en     = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q  <= '0;
      left_q <= '0;
    end else if (en) begin
      val_q  <= val_d;
      left_q <= left_d;
    end
  end
endmodule

// File: rtl/dmaw_fifo.sv
module dmaw_fifo #(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  output logic              push_ready,
  input  logic [DATA_W-1:0] push_data,
  output logic              pop_valid,
  input  logic              pop_ready,
  output logic [DATA_W-1:0] pop_data
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W:0]    wr_q, rd_q, wr_d, rd_d;
  logic              do_push, do_pop;

  assign push_ready = (wr_q - rd_q) != (PTR_W+1)'(DEPTH);
  assign pop_valid  = (wr_q != rd_q);
  assign pop_data   = mem[rd_q[PTR_W-1:0]];
  assign do_push    = push_valid && push_ready;
  assign do_pop     = pop_valid && pop_ready;

  always_comb begin
    wr_d = wr_q + (do_push ? 1'b1 : 1'b0);
    rd_d = rd_q + (do_pop ? 1'b1 : 1'b0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      wr_q <= wr_d;
      rd_q <= rd_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q[PTR_W-1:0]] <= push_data;
  end
endmodule

// File: rtl/dmaw_burst_plan.sv
module dmaw_burst_plan #(
  parameter int CNT_W     = 32,
  parameter int MAX_BEATS = 16,
  parameter int BOUNDARY  = 4096,
  parameter int BYTE_LSB  = 3
) (
  input  logic [$clog2(BOUNDARY)-BYTE_LSB-1:0] line_idx,
  input  logic [CNT_W-1:0]                     remaining,
  output logic [$clog2(MAX_BEATS+1)-1:0]       beats
);
  localparam int BEAT_W    = $clog2(MAX_BEATS+1);
  localparam int BND_WORDS = BOUNDARY >> BYTE_LSB;

  logic [CNT_W-1:0] room, cap, pick;

  always_comb begin
    room = CNT_W'(BND_WORDS) - CNT_W'(line_idx);
    cap  = CNT_W'(MAX_BEATS);
    pick = cap;
    if (room < pick)      pick = room;
    if (remaining < pick) pick = remaining;
    beats = BEAT_W'(pick);
  end
endmodule

// File: rtl/dma_burst_writer.sv
module dma_burst_writer
  import dmaw_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 64,
  parameter int CNT_W      = 32,
  parameter int MAX_BEATS  = 16,
  parameter int BOUNDARY   = 4096,
  parameter int FIFO_DEPTH = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [CNT_W-1:0]    cfg_words,
  input  logic                start,
  input  logic [DATA_W-1:0]   src_seed,
  input  logic [CNT_W-1:0]    src_count,
  input  logic                src_start,
  output logic [ADDR_W-1:0]   m_awaddr,
  output logic [7:0]          m_awlen,
  output logic [2:0]          m_awsize,
  output logic [1:0]          m_awburst,
  output logic                m_awvalid,
  input  logic                m_awready,
  output logic [DATA_W-1:0]   m_wdata,
  output logic [DATA_W/8-1:0] m_wstrb,
  output logic                m_wlast,
  output logic                m_wvalid,
  input  logic                m_wready,
  input  logic [1:0]          m_bresp,
  input  logic                m_bvalid,
  output logic                m_bready,
  output logic                busy,
  output logic                done,
  output logic                err,
  output logic [CNT_W-1:0]    cnt_aw,
  output logic [CNT_W-1:0]    cnt_w,
  output logic [CNT_W-1:0]    cnt_b
);
  localparam int BYTES    = DATA_W / 8;
  localparam int BYTE_LSB = $clog2(BYTES);
  localparam int BEAT_W   = $clog2(MAX_BEATS+1);
  localparam int BND_LSB  = $clog2(BOUNDARY);
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'(BYTES-1);

  // generator and staging FIFO
  logic              src_valid, src_ready;
  logic [DATA_W-1:0] src_data;
  logic              stg_valid, stg_ready;
  logic [DATA_W-1:0] stg_data;

  dmaw_pattern_src #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_src (
    .clk(clk), .rst_n(rst_n), .load(src_start), .seed(src_seed),
    .count(src_count), .out_valid(src_valid), .out_ready(src_ready),
    .out_data(src_data)
  );

  dmaw_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push_valid(src_valid), .push_ready(src_ready),
    .push_data(src_data), .pop_valid(stg_valid), .pop_ready(stg_ready),
    .pop_data(stg_data)
  );

  // writer state
  wr_state_t         st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  rem_q, rem_d;
  logic [7:0]        left_q, left_d;
  logic              done_q, done_d, err_q, err_d;
  logic [CNT_W-1:0]  caw_q, caw_d, cw_q, cw_d, cb_q, cb_d;
  logic [BEAT_W-1:0] beats;
  logic              aw_hs, w_hs, b_hs, go;

  dmaw_burst_plan #(
    .CNT_W(CNT_W), .MAX_BEATS(MAX_BEATS), .BOUNDARY(BOUNDARY), .BYTE_LSB(BYTE_LSB)
  ) u_plan (
    .line_idx(addr_q[BND_LSB-1:BYTE_LSB]), .remaining(rem_q), .beats(beats)
  );

  assign m_awaddr  = addr_q;
  assign m_awlen   = 8'(beats) - 8'd1;
  assign m_awsize  = 3'(BYTE_LSB);
  assign m_awburst = BURST_INCR;
  assign m_awvalid = (st_q == WR_ADDR);
  assign m_wvalid  = (st_q == WR_DATA) && stg_valid;
  assign m_wdata   = stg_data;
  assign m_wstrb   = '1;
  assign m_wlast   = (left_q == 8'd0);
  assign m_bready  = 1'b1;
  assign stg_ready = (st_q == WR_DATA) && m_wready;

  assign aw_hs = m_awvalid && m_awready;
  assign w_hs  = m_wvalid && m_wready;
  assign b_hs  = m_bvalid;
  assign go    = start && (st_q == WR_IDLE);

  assign busy   = (st_q != WR_IDLE);
  assign done   = done_q;
  assign err    = err_q;
  assign cnt_aw = caw_q;
  assign cnt_w  = cw_q;
  assign cnt_b  = cb_q;

  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    rem_d  = rem_q;
    left_d = left_q;
    done_d = done_q;
    err_d  = err_q;
    caw_d  = caw_q + (aw_hs ? 1'b1 : 1'b0);
    cw_d   = cw_q + (w_hs ? 1'b1 : 1'b0);
    cb_d   = cb_q + (b_hs ? 1'b1 : 1'b0);
    if (b_hs && (m_bresp != RESP_OKAY)) err_d = 1'b1;
    case (st_q)
      WR_IDLE: begin
        if (go) begin
          addr_d = cfg_addr & ~LOW_MASK;
          rem_d  = cfg_words;
          done_d = 1'b0;
          err_d  = 1'b0;
          caw_d  = '0;
          cw_d   = '0;
          cb_d   = '0;
          st_d   = (cfg_words == '0) ? WR_DRAIN : WR_ADDR;
        end
      end
      WR_ADDR: begin
        if (aw_hs) begin
          addr_d = addr_q + (ADDR_W'(beats) << BYTE_LSB);
          rem_d  = rem_q - CNT_W'(beats);
          left_d = 8'(beats) - 8'd1;
          st_d   = WR_DATA;
        end
      end
      WR_DATA: begin
        if (w_hs) begin
          if (left_q == 8'd0) st_d = (rem_q == '0) ? WR_DRAIN : WR_ADDR;
          else                left_d = left_q - 8'd1;
        end
      end
      WR_DRAIN: begin
        if (caw_q == cb_q) begin
          done_d = 1'b1;
          st_d   = WR_IDLE;
        end
      end
      default: st_d = WR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= WR_IDLE;
      addr_q <= '0;
      rem_q  <= '0;
      left_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      caw_q  <= '0;
      cw_q   <= '0;
      cb_q   <= '0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      rem_q  <= rem_d;
      left_q <= left_d;
      done_q <= done_d;
      err_q  <= err_d;
      caw_q  <= caw_d;
      cw_q   <= cw_d;
      cb_q   <= cb_d;
    end
  end
endmodule

// File: rtl/dmaw_checker.sv
module dmaw_checker #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 64,
  parameter int CNT_W     = 32,
  parameter int MAX_BEATS = 16,
  parameter int BOUNDARY  = 4096
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic [ADDR_W-1:0]   m_awaddr,
  input logic [7:0]          m_awlen,
  input logic [2:0]          m_awsize,
  input logic [1:0]          m_awburst,
  input logic                m_awvalid,
  input logic                m_awready,
  input logic [DATA_W-1:0]   m_wdata,
  input logic [DATA_W/8-1:0] m_wstrb,
  input logic                m_wlast,
  input logic                m_wvalid,
  input logic                m_wready,
  input logic                busy,
  input logic                done,
  input logic                err,
  input logic [CNT_W-1:0]    cnt_aw,
  input logic [CNT_W-1:0]    cnt_b
);
  localparam int BYTES = DATA_W / 8;
  localparam int BND_LSB = $clog2(BOUNDARY);

  int  end_byte;
  assign end_byte = int'(m_awaddr[BND_LSB-1:0]) + (int'(m_awlen) + 1) * BYTES;

  p_type_r2: assert property (@(posedge clk) disable iff (!rst_n)
    m_awvalid |-> (m_awburst == 2'b01) && (int'(m_awsize) == $clog2(BYTES)));

  p_len_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    m_awvalid |-> int'(m_awlen) < MAX_BEATS);

  p_no_cross_r3: assert property (@(posedge clk) disable iff (!rst_n)
    m_awvalid |-> end_byte <= BOUNDARY);

  p_strb_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    m_wvalid |-> (m_wstrb == '1));

  p_aw_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (m_awvalid && !m_awready) |=> m_awvalid && $stable(m_awaddr) && $stable(m_awlen));

  p_w_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (m_wvalid && !m_wready) |=> m_wvalid && $stable(m_wdata) && $stable(m_wlast));

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !m_awvalid && !m_wvalid);

  p_done_balance_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cnt_aw == cnt_b);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !start) |=> err);
endmodule

bind dma_burst_writer dmaw_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
  .MAX_BEATS(MAX_BEATS), .BOUNDARY(BOUNDARY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .m_awaddr(m_awaddr), .m_awlen(m_awlen),
  .m_awsize(m_awsize), .m_awburst(m_awburst), .m_awvalid(m_awvalid),
  .m_awready(m_awready), .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wlast(m_wlast),
  .m_wvalid(m_wvalid), .m_wready(m_wready), .busy(busy), .done(done), .err(err),
  .cnt_aw(cnt_aw), .cnt_b(cnt_b)
);

// File: tb/sim_dma_burst_writer.sv
module sim_dma_burst_writer;
  localparam int ADDR_W = 32, DATA_W = 64, CNT_W = 32;
  localparam int MAXB = 8, BND = 256, FDEPTH = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, start, src_start;
  logic [ADDR_W-1:0] cfg_addr, m_awaddr;
  logic [CNT_W-1:0]  cfg_words, src_count, cnt_aw, cnt_w, cnt_b;
  logic [DATA_W-1:0] src_seed, m_wdata;
  logic [7:0] m_awlen, m_wstrb;
  logic [2:0] m_awsize;
  logic [1:0] m_awburst, m_bresp;
  logic m_awvalid, m_awready, m_wlast, m_wvalid, m_wready, m_bvalid, m_bready;
  logic busy, done, err;

  dma_burst_writer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .MAX_BEATS(MAXB), .BOUNDARY(BND), .FIFO_DEPTH(FDEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_words(cfg_words),
    .start(start), .src_seed(src_seed), .src_count(src_count), .src_start(src_start),
    .m_awaddr(m_awaddr), .m_awlen(m_awlen), .m_awsize(m_awsize), .m_awburst(m_awburst),
    .m_awvalid(m_awvalid), .m_awready(m_awready), .m_wdata(m_wdata), .m_wstrb(m_wstrb),
    .m_wlast(m_wlast), .m_wvalid(m_wvalid), .m_wready(m_wready), .m_bresp(m_bresp),
    .m_bvalid(m_bvalid), .m_bready(m_bready), .busy(busy), .done(done), .err(err),
    .cnt_aw(cnt_aw), .cnt_w(cnt_w), .cnt_b(cnt_b));

  int n_chk = 0, n_err = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // slave model state
  logic [ADDR_W-1:0] rec_addr [64];
  int rec_len [64];
  int naw, nbeat, wburst, wpos, derr, lerr, oerr, serr, pend, bidx, err_burst;
  bit last_pend, throttle;
  logic [DATA_W-1:0] exp_seed;
  logic [15:0] lfsr;

  always @(negedge clk) begin
    if (!rst_n) begin
      m_awready = 1'b0; m_wready = 1'b0; m_bvalid = 1'b0; m_bresp = 2'b00;
      lfsr = 16'hACE1;
    end else begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      m_awready = throttle ? lfsr[0] : 1'b1;
      m_wready  = throttle ? (lfsr[3] | lfsr[5]) : 1'b1;
      if (last_pend) begin pend++; last_pend = 1'b0; end
      if (m_bvalid) begin
        m_bvalid = 1'b0; pend--; bidx++;
      end else if (pend > 0) begin
        m_bvalid = 1'b1;
        m_bresp  = (bidx == err_burst) ? 2'b10 : 2'b00;
      end
      if (m_awvalid && m_awready) begin
        if (m_awburst != 2'b01 || m_awsize != 3'd3) serr++;
        if (naw < 64) begin rec_addr[naw] = m_awaddr; rec_len[naw] = int'(m_awlen); end
        naw++;
      end
      if (m_wvalid && m_wready) begin
        if (m_wdata != exp_seed + DATA_W'(nbeat)) derr++;
        if (m_wstrb != 8'hFF) lerr++;
        if (wburst >= naw || wburst >= 64) oerr++;
        else if (m_wlast != (wpos == rec_len[wburst])) lerr++;
        if (m_wlast) begin wburst++; wpos = 0; last_pend = 1'b1; end
        else wpos++;
        nbeat++;
      end
    end
  end

  // run one transfer and check the common requirements
  task automatic run(input string tag, input logic [ADDR_W-1:0] addr, input int words,
                     input logic [DATA_W-1:0] seed, input bit thr, input int eb,
                     input bit poke);
    logic [ADDR_W-1:0] a;
    int rem, n_exp, bad, cyc, b;
    @(negedge clk);
    naw = 0; nbeat = 0; wburst = 0; wpos = 0; derr = 0; lerr = 0; oerr = 0; serr = 0;
    pend = 0; bidx = 0; last_pend = 1'b0;
    throttle = thr; err_burst = eb; exp_seed = seed;
    cfg_addr = addr; cfg_words = CNT_W'(words); src_seed = seed; src_count = CNT_W'(words);
    start = 1'b1; src_start = 1'b1;
    @(negedge clk);
    start = 1'b0; src_start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      check(busy == 1'b1, "R11", {tag, " busy before poke"}, longint'(busy), 1);
      cfg_addr = 32'h40; cfg_words = 2; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    cyc = 0;
    while (!done && cyc < 3000) begin @(negedge clk); cyc++; end
    check(done == 1'b1, "R7", {tag, " done reached"}, longint'(done), 1);
    // expected burst plan
    a = addr & ~32'h7; rem = words; n_exp = 0; bad = 0;
    while (rem > 0) begin
      b = (BND - int'(a % BND)) / 8;
      if (b > MAXB) b = MAXB;
      if (b > rem) b = rem;
      if (n_exp < 64 && (rec_addr[n_exp] != a || rec_len[n_exp] != b - 1)) bad++;
      a = a + ADDR_W'(b * 8); rem -= b; n_exp++;
    end
    check(naw == n_exp, "R3", {tag, " burst count"}, naw, n_exp);
    check(bad == 0, "R2", {tag, " burst address/length mismatches"}, bad, 0);
    check(serr == 0, "R2", {tag, " burst type/size"}, serr, 0);
    check(nbeat == words, "R6", {tag, " beat total"}, nbeat, words);
    check(oerr == 0, "R6", {tag, " beat before address"}, oerr, 0);
    check(derr == 0, "R10", {tag, " data pattern errors"}, derr, 0);
    check(lerr == 0, "R4", {tag, " last/strobe errors"}, lerr, 0);
    check(cnt_aw == CNT_W'(n_exp), "R9", {tag, " cnt_aw"}, cnt_aw, n_exp);
    check(cnt_w == CNT_W'(words), "R9", {tag, " cnt_w"}, cnt_w, words);
    check(cnt_b == CNT_W'(n_exp), "R9", {tag, " cnt_b"}, cnt_b, n_exp);
    repeat (4) @(negedge clk);
    check(done == 1'b1 && busy == 1'b0, "R7", {tag, " done held"}, longint'(done), 1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; src_start = 1'b0;
    cfg_addr = '0; cfg_words = '0; src_seed = '0; src_count = '0;
    throttle = 1'b0; err_burst = -1;
    naw = 0; pend = 0; last_pend = 1'b0;
    repeat (3) @(negedge clk);
    check(!m_awvalid && !m_wvalid && !busy && !done && !err, "R1", "outputs in reset",
          {m_awvalid, m_wvalid, busy, done, err}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!m_awvalid && !m_wvalid && !busy && !done && !err, "R1", "outputs after reset",
          {m_awvalid, m_wvalid, busy, done, err}, 0);
    check(cnt_aw == 0 && cnt_w == 0 && cnt_b == 0, "R1", "counters after reset",
          cnt_aw + cnt_w + cnt_b, 0);
  endtask

  task automatic t_plain();      // R2 R3 caps at MAX_BEATS
    run("plain", 32'h1000, 20, 64'h100, 1'b0, -1, 1'b0);
    check(err == 1'b0, "R8", "plain err clear", longint'(err), 0);
  endtask

  task automatic t_boundary();   // R3 boundary split under throttling
    run("boundary", 32'h10F0, 27, 64'h5555_0000, 1'b1, -1, 1'b0);
  endtask

  task automatic t_unaligned();  // R2 low address bits cleared
    run("unaligned", 32'h2203, 5, 64'h9, 1'b1, -1, 1'b0);
    check(rec_addr[0] == 32'h2200, "R2", "aligned first address", rec_addr[0], 32'h2200);
  endtask

  task automatic t_error();      // R8 sticky error
    run("error", 32'h3000, 24, 64'h77, 1'b1, 1, 1'b0);
    check(err == 1'b1, "R8", "err after bad response", longint'(err), 1);
  endtask

  task automatic t_poke();       // R11 start while busy ignored, R8 err cleared
    run("poke", 32'h40F8, 18, 64'hABC, 1'b1, -1, 1'b1);
    check(err == 1'b0, "R8", "err cleared by new start", longint'(err), 0);
  endtask

  task automatic t_zero();       // R7 zero word count
    run("zero", 32'h5000, 0, 64'h1, 1'b0, -1, 1'b0);
  endtask

  task automatic t_wrap();       // R10 seed wraparound
    run("wrap", 32'h6000, 5, 64'hFFFF_FFFF_FFFF_FFFE, 1'b1, -1, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_plain();
    t_boundary();
    t_unaligned();
    t_error();
    t_poke();
    t_zero();
    t_wrap();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule